// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is a small set of 32-bit memory-mapped registers that drive a single level-sensitive interrupt line. Software rings the doorbell through particular register writes. Some writes, or particular data bits within them, set the line. Other writes clear it. The line then holds its level until the next such event. The line is not a status-AND-enable function. It is an event latch, and the register contents never feed it.

The block hangs off a simple single-cycle register bus with a byte address, a write strobe, write data, a read strobe and read data. It holds two outbound descriptor words, a control word, an interrupt status word and a software interrupt word. Every access is a full 32-bit word. The two lowest address bits are not looked at, and there are no bus error responses.

Top module: `doorbell_irq_regs`

## Requirements
- R1: Address decode uses byte address bits [ADDR_W-1:2] only: 0x028 is descriptor A, 0x02C is descriptor B, 0x04C is control, 0x050 is status, 0x1F0 is software-interrupt set, and 0x1F4 is software-interrupt clear. Bits [1:0] are ignored, so 0x04F reads control.
- R2: A read of control returns the stored word with bit 17 forced to 1. All other bits come from storage.
- R3: A write to descriptor B stores the full word. When write data bit 29 is 1, `irq_o` is 1 in the cycle after the write.
- R4: A write to control stores the full word. When write data bit 16 is 1, `irq_o` is 0 in the cycle after the write.
- R5: A write to status stores the full word as given, with no write-one-to-clear. When write data bit 16 or bit 29 is 1, `irq_o` is 0 afterwards.
- R6: A write to the set address ORs the data into the software-interrupt word and always sets `irq_o`, even when the data is zero.
- R7: A write to the clear address clears the software-interrupt bits that are 1 in the data and always clears `irq_o`, even when other bits stay set.
- R8: A read at either the set address or the clear address returns the current software-interrupt word.
- R9: A read at an undecoded address returns zero. A write at an undecoded address changes no register and leaves `irq_o` as it was.
- R10: While `rst_n` is low at a clock edge, all five registers clear to zero and `irq_o` clears to 0.
- R11: `irq_o` keeps its level until a setting or clearing event occurs. A write to descriptor A stores its word and never changes `irq_o`.
- R12: `bus_rdata` carries the read value in the cycle after a cycle with `bus_rd` high. In the cycle after a cycle with `bus_rd` low, it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address (bits [1:0] ignored) |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, registered, valid one cycle after the strobe |
| irq_o | output | 1 | Level interrupt line |

## Verification
The interrupt event logic is tried with write data that has each trigger bit alone, with data that has no trigger bit, and with all-ones data at addresses that must not react. This separates a decode that looks at the right bit from one that looks at the whole word or at the wrong register. Set and clear writes with zero data, and a clear that leaves software bits nonzero, show that the line follows events and not register contents. Repeated set writes with disjoint masks, together with readback through both the set and the clear address, show OR accumulation as opposed to overwrite. Aliased addresses with nonzero low bits, undecoded addresses, and a reset in the middle of a run check the decode and the clearing paths.

// File: rtl/db_pkg.sv
// Shared constants for the doorbell interrupt register block.
// Assumes DATA_W >= 30 so that every trigger bit exists, and ADDR_W <= 16.
package db_pkg;

    localparam int NUM_SLOTS   = 6;
    localparam int SLOT_DESC_A = 0;
    localparam int SLOT_DESC_B = 1;
    localparam int SLOT_CTRL   = 2;
    localparam int SLOT_STAT   = 3;
    localparam int SLOT_SW_SET = 4;
    localparam int SLOT_SW_CLR = 5;

    localparam int BIT_DESCB_RAISE = 29;
    localparam int BIT_CTRL_LOWER  = 16;
    localparam int BIT_STAT_LOW_A  = 16;
    localparam int BIT_STAT_LOW_B  = 29;
    localparam int BIT_CTRL_FORCED = 17;

    // Byte offset of each decoded slot.
    function automatic logic [15:0] slot_offset(input int idx);
        case (idx)
            SLOT_DESC_A: slot_offset = 16'h0028;
            SLOT_DESC_B: slot_offset = 16'h002C;
            SLOT_CTRL:   slot_offset = 16'h004C;
            SLOT_STAT:   slot_offset = 16'h0050;
            SLOT_SW_SET: slot_offset = 16'h01F0;
            SLOT_SW_CLR: slot_offset = 16'h01F4;
            default:     slot_offset = 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/db_addr_decode.sv
// Word address decoder. Produces a one-hot hit vector with one bit per slot.
// Assumes the byte address is word aligned in intent; bits [1:0] are dropped.
module db_addr_decode
    import db_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_SLOTS-1:0] hit
);

    logic unused_low;
    assign unused_low = ^addr[1:0];

    // One comparator per slot against its word index.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [15:0] OFF = slot_offset(g);
        assign hit[g] = (addr[ADDR_W-1:2] == OFF[ADDR_W-1:2]);
    end

endmodule

// File: rtl/db_regfile.sv
// Register storage and read path. Holds the two descriptor words, control,
// status and the software interrupt word. Read data is registered and is
// zero after a cycle with no read strobe. Assumes one access per cycle.
module db_regfile
    import db_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] hit,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 rd_en,
    output logic [DATA_W-1:0]    rdata
);

    localparam logic [DATA_W-1:0] CTRL_FORCE = DATA_W'(1) << BIT_CTRL_FORCED;

    logic [DATA_W-1:0] desc_a_q, desc_b_q, ctrl_q, stat_q, swirq_q;
    logic [DATA_W-1:0] rd_word;

    // Plain word storage for the four data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_a_q <= '0;
            desc_b_q <= '0;
            ctrl_q   <= '0;
            stat_q   <= '0;
        end else if (wr_en) begin
            if (hit[SLOT_DESC_A]) desc_a_q <= wdata;
            if (hit[SLOT_DESC_B]) desc_b_q <= wdata;
            if (hit[SLOT_CTRL])   ctrl_q   <= wdata;
            if (hit[SLOT_STAT])   stat_q   <= wdata;
        end
    end

    // Software interrupt word: OR on set address, mask-clear on clear address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swirq_q <= '0;
        end else if (wr_en) begin
            if (hit[SLOT_SW_SET])      swirq_q <= swirq_q | wdata;
            else if (hit[SLOT_SW_CLR]) swirq_q <= swirq_q & ~wdata;
        end
    end

    // Read multiplexer; undecoded addresses give zero.
    always_comb begin
        rd_word = '0;
        if (hit[SLOT_DESC_A]) rd_word = desc_a_q;
        if (hit[SLOT_DESC_B]) rd_word = desc_b_q;
        if (hit[SLOT_CTRL])   rd_word = ctrl_q | CTRL_FORCE;
        if (hit[SLOT_STAT])   rd_word = stat_q;
        if (hit[SLOT_SW_SET] || hit[SLOT_SW_CLR]) rd_word = swirq_q;
    end

    // Registered read data, cleared when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_en ? rd_word : '0;
    end

endmodule

// File: rtl/db_irq_ctrl.sv
// Interrupt event latch. Specific writes and data bits set or clear a
// registered level; register contents never feed it. Assumes a one-hot hit.
module db_irq_ctrl
    import db_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] hit,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 irq
);

    logic raise_ev, lower_ev;
    logic unused_w;
    assign unused_w = ^{hit, wdata};

    // Classify the current write as a set event, a clear event or neither.
    always_comb begin
        raise_ev = wr_en && ((hit[SLOT_DESC_B] && wdata[BIT_DESCB_RAISE])
                             || hit[SLOT_SW_SET]);
        lower_ev = wr_en && ((hit[SLOT_CTRL] && wdata[BIT_CTRL_LOWER])
                             || (hit[SLOT_STAT] && (wdata[BIT_STAT_LOW_A]
                                                    || wdata[BIT_STAT_LOW_B]))
                             || hit[SLOT_SW_CLR]);
    end

    // Level latch: holds until the next event.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (raise_ev) irq <= 1'b1;
        else if (lower_ev) irq <= 1'b0;
    end

endmodule

// File: rtl/doorbell_irq_regs.sv
// Top of the doorbell interrupt register block: decoder, register file and
// interrupt latch. Single-cycle bus, full-word accesses only.
module doorbell_irq_regs
    import db_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    logic [NUM_SLOTS-1:0] hit;

    db_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    db_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .wr_en (bus_wr),
        .wdata (bus_wdata),
        .rd_en (bus_rd),
        .rdata (bus_rdata)
    );

    db_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .wr_en (bus_wr),
        .wdata (bus_wdata),
        .irq   (irq_o)
    );

endmodule

// File: rtl/db_checker.sv
// Port-level protocol checker for doorbell_irq_regs, attached by bind.
// Decodes addresses on its own from the byte offsets.
module db_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o
);

    logic [ADDR_W-3:0] w;
    logic unused_c;
    assign w = bus_addr[ADDR_W-1:2];
    assign unused_c = ^{bus_addr[1:0], bus_wdata};

    logic at_b, at_ctrl, at_stat, at_set, at_clr, at_any;
    assign at_b    = (w == (ADDR_W-2)'(12'h02C >> 2));
    assign at_ctrl = (w == (ADDR_W-2)'(12'h04C >> 2));
    assign at_stat = (w == (ADDR_W-2)'(12'h050 >> 2));
    assign at_set  = (w == (ADDR_W-2)'(12'h1F0 >> 2));
    assign at_clr  = (w == (ADDR_W-2)'(12'h1F4 >> 2));
    assign at_any  = at_b || at_ctrl || at_stat || at_set || at_clr
                     || (w == (ADDR_W-2)'(12'h028 >> 2));

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !irq_o); // R10
    AST_DESCB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_b && bus_wdata[29]) |=> irq_o); // R3
    AST_CTRL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_ctrl && bus_wdata[16]) |=> !irq_o); // R4
    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_stat && (bus_wdata[16] || bus_wdata[29])) |=> !irq_o); // R5
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_set) |=> irq_o); // R6
    AST_SW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_clr) |=> !irq_o); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || !at_any) |=> $stable(irq_o)); // R11
    AST_UNDEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !at_any) |=> (bus_rdata == '0)); // R9
    AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_ctrl) |=> bus_rdata[17]); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R12

endmodule

bind doorbell_irq_regs db_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
);

// File: tb/tb_doorbell_irq_regs.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_doorbell_irq_regs;

    localparam logic [11:0] A_DA  = 12'h028;
    localparam logic [11:0] A_DB  = 12'h02C;
    localparam logic [11:0] A_CTL = 12'h04C;
    localparam logic [11:0] A_ST  = 12'h050;
    localparam logic [11:0] A_SET = 12'h1F0;
    localparam logic [11:0] A_CLR = 12'h1F4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    doorbell_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        chk("R10 irq after reset", 32'(irq_o), 32'd0);
        brd(A_DA, v);  chk("R10 desc A", v, 32'h0);
        brd(A_DB, v);  chk("R10 desc B", v, 32'h0);
        brd(A_CTL, v); chk("R2 R10 ctrl", v, 32'h0002_0000);
        brd(A_ST, v);  chk("R10 status", v, 32'h0);
        brd(A_SET, v); chk("R10 swirq", v, 32'h0);
    endtask

    task automatic t_desc_a();
        logic [31:0] v;
        bwr(A_DA, 32'hFFFF_FFFF);
        chk("R11 desc A write no irq", 32'(irq_o), 32'd0);
        brd(A_DA, v); chk("R11 desc A stored", v, 32'hFFFF_FFFF);
        bwr(A_SET, 32'h0);
        bwr(A_DA, 32'h0);
        chk("R11 desc A write keeps irq high", 32'(irq_o), 32'd1);
        bwr(A_CLR, 32'h0);
    endtask

    task automatic t_desc_b();
        logic [31:0] v;
        bwr(A_DB, 32'hDFFF_FFFF);
        chk("R3 no bit29 no irq", 32'(irq_o), 32'd0);
        brd(A_DB, v); chk("R3 desc B stored", v, 32'hDFFF_FFFF);
        bwr(A_DB, 32'h2000_0000);
        chk("R3 bit29 raises", 32'(irq_o), 32'd1);
        bwr(A_DB, 32'h0000_1234);
        chk("R11 irq holds", 32'(irq_o), 32'd1);
        repeat (3) @(negedge clk);
        chk("R11 irq holds idle", 32'(irq_o), 32'd1);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        bwr(A_CTL, 32'h0000_0005);
        chk("R4 no bit16 keeps irq", 32'(irq_o), 32'd1);
        brd(A_CTL, v); chk("R2 ctrl read forced", v, 32'h0002_0005);
        bwr(A_CTL, 32'h0001_0000);
        chk("R4 bit16 lowers", 32'(irq_o), 32'd0);
        brd(A_CTL, v); chk("R4 ctrl stored", v, 32'h0003_0000);
    endtask

    task automatic t_status();
        logic [31:0] v;
        bwr(A_SET, 32'h0);
        bwr(A_ST, 32'h0000_00A5);
        chk("R5 no trigger keeps irq", 32'(irq_o), 32'd1);
        brd(A_ST, v); chk("R5 status stored", v, 32'h0000_00A5);
        bwr(A_ST, 32'h2000_0000);
        chk("R5 bit29 lowers", 32'(irq_o), 32'd0);
        brd(A_ST, v); chk("R5 not W1C", v, 32'h2000_0000);
        bwr(A_SET, 32'h0);
        bwr(A_ST, 32'h0001_0000);
        chk("R5 bit16 lowers", 32'(irq_o), 32'd0);
    endtask

    task automatic t_swirq();
        logic [31:0] v;
        bwr(A_SET, 32'h0);
        chk("R6 zero set raises", 32'(irq_o), 32'd1);
        brd(A_SET, v); chk("R6 zero set no bits", v, 32'h0);
        bwr(A_SET, 32'h0000_000F);
        bwr(A_SET, 32'h0000_00F0);
        brd(A_SET, v); chk("R6 OR accumulate", v, 32'h0000_00FF);
        brd(A_CLR, v); chk("R8 read via clear addr", v, 32'h0000_00FF);
        bwr(A_CLR, 32'h0000_0003);
        chk("R7 clear lowers with bits left", 32'(irq_o), 32'd0);
        brd(A_SET, v); chk("R7 bits cleared", v, 32'h0000_00FC);
        bwr(A_CLR, 32'h0);
        chk("R7 zero clear keeps low", 32'(irq_o), 32'd0);
    endtask

    task automatic t_undecoded();
        logic [31:0] v;
        bwr(A_SET, 32'h0);
        bwr(12'h100, 32'hFFFF_FFFF);
        bwr(12'h030, 32'hFFFF_FFFF);
        chk("R9 undecoded write keeps irq", 32'(irq_o), 32'd1);
        brd(12'h100, v); chk("R9 undecoded read zero", v, 32'h0);
        brd(A_ST, v);    chk("R9 status untouched", v, 32'h0001_0000);
        brd(A_DB, v);    chk("R9 desc B untouched", v, 32'h0000_1234);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        brd(12'h04F, v); chk("R1 low bits ignored ctrl", v, 32'h0003_0000);
        bwr(12'h1F6, 32'h0);
        chk("R1 aliased clear lowers", 32'(irq_o), 32'd0);
        bwr(12'h02D, 32'h2000_0000);
        chk("R1 aliased desc B raises", 32'(irq_o), 32'd1);
    endtask

    task automatic t_idle_rdata();
        logic [31:0] v;
        brd(A_CTL, v);
        @(negedge clk);
        chk("R12 rdata zero when idle", bus_rdata, 32'h0);
    endtask

    task automatic t_mid_reset();
        do_reset();
        chk("R10 irq cleared mid run", 32'(irq_o), 32'd0);
        t_reset_state();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_desc_a();
        t_desc_b();
        t_ctrl();
        t_status();
        t_swirq();
        t_undecoded();
        t_alias();
        t_idle_rdata();
        t_mid_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule